// File: doc/BRIEF.md
# Invertible 18-bit XOR Mixing Unit

This block applies a fixed, invertible linear map over GF(2) to an 18-bit word, built entirely from XOR trees. A two-bit mode input picks one of three paths through the same datapath: a straight pass-through, the forward mixing matrix, or that matrix's exact inverse. A word presented with a valid strobe produces a registered result and a one-cycle valid flag on the following clock.

The same load also copies the result into an 18-bit shift register. The register then streams the result out on a single wire, most significant bit first, one bit per clock. A completion flag rises once all eighteen bits have left. A new load at any time restarts the stream with the new result.

The inverse matrix is not entered by hand. It is derived at elaboration by Gauss-Jordan elimination over the forward column table, so the decode path always matches the encode path exactly.

Top module: `xmix_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `outData` is 0 and `outValid`, `serOut` and `serDone` are all 0.
- R2: Mode 2'b00 (direct) and mode 2'b11 both give `outData` equal to the input word.
- R3: In mode 2'b01 (encode), a word with only bit k set maps to this hex image: k0 377D9, k1 377DF, k2 37BDF, k3 37B9F, k4 179B5, k5 31ACA, k6 007F8, k7 2EE40, k8 3F0A0, k9 3F7F9, k10 3EFF9, k11 3EFF5, k12 0DFD5, k13 078B5, k14 37026, k15 3F02C, k16 21370, k17 007FA.
- R4: Encode is linear. Any word maps to the XOR of the images of its set bits, for example 3FFFF to 2BE34, 3FE00 to 1C415, 001FF to 37A21, 2AAAA to 26FA5 and 15555 to 0D191. An all-zero word gives zero in every mode.
- R5: Mode 2'b10 (decode) is the exact inverse of encode. Decoding the encode result of any x returns x, and decoding 2BE34 returns 3FFFF.
- R6: `outData` and `outValid` update on the clock edge that samples `inValid` high. `outValid` is high for one cycle per accepted word, and `outData` holds its value while `inValid` is low.
- R7: After a load edge, `serOut` shows result bit 17. After n more clocks (n from 1 to 17), it shows result bit 17-n.
- R8: `serDone` is low in the cycle after any load. It rises on the 18th clock after the load and then stays high until the next load.
- R9: A load while a stream is in progress discards the old stream. The new result streams from bit 17, and `serDone` timing restarts from the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 18 | Input word |
| mode | input | 2 | 00 direct, 01 encode, 10 decode, 11 direct |
| inValid | input | 1 | Input word strobe |
| outData | output | 18 | Registered transform result |
| outValid | output | 1 | One-cycle pulse marking a new result |
| serOut | output | 1 | Serial result stream, MSB first |
| serDone | output | 1 | High once all 18 bits have been shifted out |

## Verification
A new parallel load and a serializer shift can fall on the same clock edge. This happens when `inValid` arrives while an earlier stream is still running. The bench provokes the collision by loading a second word seven clocks into a stream. It then requires the new result's bit 17 on `serOut` at once, the full new bit sequence after that, and `serDone` held low until exactly 18 clocks after the second load. A shift that wins over the load, or a counter that is not cleared, shows up as a wrong bit or an early done flag.

// File: rtl/xmix_pkg.sv
package xmix_pkg;

  localparam int W = 18;
  localparam int CNT_W = $clog2(W);

  typedef logic [W-1:0][W-1:0] mat_t;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_ENCODE = 2'b01,
    MODE_DECODE = 2'b10,
    MODE_ALT    = 2'b11
  } mode_t;

  typedef struct packed {
    logic load;
    logic shift;
  } ctrlStrobe_t;

  // Forward matrix by column: entry k is the image of input bit k.
  localparam mat_t FWD_COLS = {
    18'h007FA, 18'h21370, 18'h3F02C, 18'h37026, 18'h078B5, 18'h0DFD5,
    18'h3EFF5, 18'h3EFF9, 18'h3F7F9, 18'h3F0A0, 18'h2EE40, 18'h007F8,
    18'h31ACA, 18'h179B5, 18'h37B9F, 18'h37BDF, 18'h377DF, 18'h377D9
  };

  // Gauss-Jordan over GF(2). The returned row i selects the encoded bits
  // whose parity reconstructs original bit i.
  function automatic mat_t invertRows(input mat_t cols);
    mat_t a;
    mat_t b;
    logic [W-1:0] t;
    int p;
    for (int i = 0; i < W; i++) begin
      b[i] = '0;
      b[i][i] = 1'b1;
      for (int j = 0; j < W; j++) a[i][j] = cols[j][i];
    end
    for (int c = 0; c < W; c++) begin
      p = -1;
      for (int r = c; r < W; r++)
        if (p < 0 && a[r][c]) p = r;
      if (p >= 0) begin
        t = a[c]; a[c] = a[p]; a[p] = t;
        t = b[c]; b[c] = b[p]; b[p] = t;
      end
      for (int r = 0; r < W; r++) begin
        if (r != c && a[r][c]) begin
          a[r] = a[r] ^ a[c];
          b[r] = b[r] ^ b[c];
        end
      end
    end
    return b;
  endfunction

  localparam mat_t INV_ROWS = invertRows(FWD_COLS);

endpackage

// File: rtl/xmix_ctrl.sv
module xmix_ctrl
  import xmix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        serDone
);

  logic             active;
  logic [CNT_W-1:0] shiftCnt;
  localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(W - 1);

  // A load always wins over a shift that falls on the same edge.
  always_comb begin
    strobe.load  = inValid;
    strobe.shift = active && !inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      shiftCnt <= '0;
      serDone  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (strobe.load) begin
        active   <= 1'b1;
        shiftCnt <= '0;
        serDone  <= 1'b0;
      end else if (strobe.shift) begin
        shiftCnt <= shiftCnt + 1'b1;
        if (shiftCnt == LAST_SHIFT) begin
          active  <= 1'b0;
          serDone <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R6
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> !serDone); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    serDone && !inValid |=> serDone); // R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    active |-> shiftCnt <= LAST_SHIFT); // R9

endmodule

// File: rtl/xmix_datapath.sv
module xmix_datapath
  import xmix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [1:0]  mode,
  input  logic [W-1:0] inData,
  output logic [W-1:0] outData,
  output logic        serOut
);

  logic [W-1:0] encWord;
  logic [W-1:0] decWord;
  logic [W-1:0] nextWord;
  logic [W-1:0] shiftReg;

  // Forward map: XOR of the column images selected by the set input bits.
  logic [W-1:0] encTerm [W];
  generate
    for (genvar k = 0; k < W; k++) begin : g_encCol
      assign encTerm[k] = inData[k] ? FWD_COLS[k] : '0;
    end
  endgenerate

  always_comb begin
    encWord = '0;
    for (int k = 0; k < W; k++) encWord = encWord ^ encTerm[k];
  end

  // Inverse map: each output bit is the parity of a fixed subset of inputs.
  generate
    for (genvar i = 0; i < W; i++) begin : g_decRow
      assign decWord[i] = ^(INV_ROWS[i] & inData);
    end
  endgenerate

  always_comb begin
    unique case (mode_t'(mode))
      MODE_ENCODE: nextWord = encWord;
      MODE_DECODE: nextWord = decWord;
      default:     nextWord = inData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      shiftReg <= '0;
    end else if (strobe.load) begin
      outData  <= nextWord;
      shiftReg <= nextWord;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[W-2:0], 1'b0};
    end
  end

  assign serOut = shiftReg[W-1];

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && (mode == MODE_DIRECT || mode == MODE_ALT)
      |=> outData == $past(inData)); // R2
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && inData == '0 |=> outData == '0); // R4
  AST_SER_MSB: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> serOut == outData[W-1]); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outData)); // R6

endmodule

// File: rtl/xmix_unit.sv
module xmix_unit
  import xmix_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  inData,
  input  logic [1:0]    mode,
  input  logic          inValid,
  output logic [W-1:0]  outData,
  output logic          outValid,
  output logic          serOut,
  output logic          serDone
);

  ctrlStrobe_t strobe;

  xmix_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid),
    .serDone  (serDone)
  );

  xmix_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mode    (mode),
    .inData  (inData),
    .outData (outData),
    .serOut  (serOut)
  );

endmodule

// File: tb/xmix_unit_tb_top.sv
module xmix_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] inData = '0;
  logic [1:0]  mode = 2'b00;
  logic        inValid = 1'b0;
  logic [17:0] outData;
  logic        outValid, serOut, serDone;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xmix_unit dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .mode(mode),
    .inValid(inValid), .outData(outData), .outValid(outValid),
    .serOut(serOut), .serDone(serDone)
  );

  // {mode, input, expected}
  localparam int NV = 27;
  localparam logic [37:0] VEC [NV] = '{
    {2'b01, 18'h00000, 18'h00000},
    {2'b01, 18'h00001, 18'h377D9}, {2'b01, 18'h00002, 18'h377DF},
    {2'b01, 18'h00004, 18'h37BDF}, {2'b01, 18'h00008, 18'h37B9F},
    {2'b01, 18'h00010, 18'h179B5}, {2'b01, 18'h00020, 18'h31ACA},
    {2'b01, 18'h00040, 18'h007F8}, {2'b01, 18'h00080, 18'h2EE40},
    {2'b01, 18'h00100, 18'h3F0A0}, {2'b01, 18'h00200, 18'h3F7F9},
    {2'b01, 18'h00400, 18'h3EFF9}, {2'b01, 18'h00800, 18'h3EFF5},
    {2'b01, 18'h01000, 18'h0DFD5}, {2'b01, 18'h02000, 18'h078B5},
    {2'b01, 18'h04000, 18'h37026}, {2'b01, 18'h08000, 18'h3F02C},
    {2'b01, 18'h10000, 18'h21370}, {2'b01, 18'h20000, 18'h007FA},
    {2'b01, 18'h3FFFF, 18'h2BE34}, {2'b01, 18'h3FE00, 18'h1C415},
    {2'b01, 18'h001FF, 18'h37A21}, {2'b01, 18'h2AAAA, 18'h26FA5},
    {2'b01, 18'h15555, 18'h0D191},
    {2'b10, 18'h2BE34, 18'h3FFFF},
    {2'b00, 18'h2D1C3, 18'h2D1C3}, {2'b11, 18'h1B0E6, 18'h1B0E6}
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one word; returns the sampled result one cycle later.
  task automatic apply(input logic [1:0] m, input logic [17:0] d, output logic [17:0] r);
    @(negedge clk);
    mode = m; inData = d; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    r = outData;
  endtask

  task automatic watchStream(input logic [17:0] word, input string req);
    for (int n = 1; n < 18; n++) begin
      @(negedge clk);
      check(req, {17'd0, serOut}, {17'd0, word[17-n]});
      check("R8", {17'd0, serDone}, 18'd0);
    end
    @(negedge clk);
    check("R8", {17'd0, serDone}, 18'd1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [17:0] r, e, lfsr;
    repeat (2) @(negedge clk);
    check("R1", {outValid, serOut, serDone, outData[14:0]}, 18'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", outData, 18'd0);
    check("R1", {15'd0, outValid, serOut, serDone}, 18'd0);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][37:36], VEC[i][35:18], r);
      check("R3/R4 table", r, VEC[i][17:0]);
      check("R6", {17'd0, outValid}, 18'd1);
    end

    // R6 hold and single pulse
    @(negedge clk);
    check("R6", {17'd0, outValid}, 18'd0);
    check("R6", outData, 18'h1B0E6);

    // R4 zero in every mode
    for (int m = 0; m < 4; m++) begin
      apply(2'(m), 18'h0, r);
      check("R4", r, 18'h0);
    end

    // R5 round trip on basis vectors and pseudo-random words
    for (int i = -1; i < 18; i++) begin
      e = (i < 0) ? 18'h0 : (18'h1 << i);
      apply(2'b01, e, r);
      apply(2'b10, r, r);
      check("R5", r, e);
    end
    lfsr = 18'h2A5C1;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
      apply(2'b01, lfsr, r);
      apply(2'b10, r, r);
      check("R5", r, lfsr);
    end

    // R7 R8 full stream
    apply(2'b01, 18'h2AAAA, r);
    check("R7", {17'd0, serOut}, {17'd0, r[17]});
    check("R8", {17'd0, serDone}, 18'd0);
    watchStream(18'h26FA5, "R7");
    repeat (3) @(negedge clk);
    check("R8", {17'd0, serDone}, 18'd1);

    // R9 restart mid-stream
    apply(2'b00, 18'h3C00F, r);
    repeat (7) @(negedge clk);
    apply(2'b01, 18'h3FFFF, r);
    check("R9", r, 18'h2BE34);
    check("R9", {17'd0, serOut}, {17'd0, r[17]});
    check("R8", {17'd0, serDone}, 18'd0);
    watchStream(18'h2BE34, "R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule